// File: doc/BRIEF.md
# Selectable IQ Test Stimulus Generator

This block drives a complex sample stream (I + jQ, two signed 16-bit components) into the first stage of a DSP chain under test. At run time a small register port selects one of five stimuli: silence, a single-frequency tone from a phase accumulator and quarter-wave sine table, a one-shot impulse, a pseudo-random ±½-scale bit stream, or a passthrough of a stream supplied on a second input. Each stimulus targets one class of fault. Silence shows DC offset, spurs and reset faults. The tone shows the frequency plan and the sign of frequency shifts. The impulse shows filter response and latency. The bit stream shows the bit pipeline and error counting. The passthrough runs the chain without any RF path.

The output uses a valid/ready handshake. Generator state advances only on an accepted transfer, so backpressure never drops or repeats a sample. Writing the mode register re-arms the selected generator. The mode can therefore be changed, or a stimulus restarted, without touching the logic.

Top module: `iq_stim_gen`

## Requirements
- R1: After reset, enable is 0, the mode is 0 (silence), the phase increment is 0, `out_valid` is 0 and `lb_ready` is 0.
- R2: Register writes (`cfg_we` high for one cycle) take effect at that clock edge. Address 0 sets the mode from `cfg_wdata[2:0]`. Address 1 sets enable from `cfg_wdata[0]`. Address 2 sets the phase increment from `cfg_wdata[15:0]`. A write to address 3 changes nothing.
- R3: While enable is 0, `out_valid` is 0. While enable is 1 in any mode other than passthrough, `out_valid` is 1.
- R4: Mode 0 outputs I = 0 and Q = 0. The codes 5, 6 and 7 behave the same as mode 0.
- R5: Mode 1 (tone) outputs I = cos and Q = sin of the phase p, where p is the top 6 bits of a 16-bit phase accumulator (angle 2πp/64). Each component is within ±2 of round(32767·cos) and round(32767·sin). The accumulator adds the increment on every accepted transfer.
- R6: Mode 2 (impulse) outputs I = 32767, Q = 0 on the first accepted transfer after a mode write or after enable goes from 0 to 1. All later samples are I = 0, Q = 0.
- R7: Mode 3 (bit stream) uses a 7-bit register s with output bit s[6] and update s ← {s[5:0], s[6]^s[5]} (polynomial x^7 + x^6 + 1) on each accepted transfer. Bit 0 gives I = +16383 and bit 1 gives I = −16383. Q is always 0.
- R8: The bit-stream register is all ones after reset and after every mode write, so the sequence restarts from its first bit.
- R9: Mode 4 (passthrough) sets `out_valid = lb_valid`, `out_i = lb_i`, `out_q = lb_q` and `lb_ready = out_ready`, all within the same cycle. In every other mode, and whenever enable is 0, `lb_ready` is 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output sample holds and no generator state advances.
- R11: A mode write clears the tone phase to 0, even when it writes the same mode again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| lb_valid | input | 1 | Passthrough source valid |
| lb_ready | output | 1 | Passthrough source ready |
| lb_i | input | 16 | Passthrough source I |
| lb_q | input | 16 | Passthrough source Q |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Output sample ready from the consumer |
| out_i | output | 16 | Output I, signed |
| out_q | output | 16 | Output Q, signed |

## Verification
The bench uses random `out_ready` gaps throughout. A design that advanced the phase, the bit register or the impulse flag on valid alone would then skip samples, and the cycle-by-cycle model would catch it. It rewrites the mode with the same value to check restart of phase and bit sequence: a design that re-armed only on a change of mode would continue mid-sequence. It toggles enable off and on in impulse mode, where a missing re-arm would give no second impulse. It also writes the unused codes 5 to 7 and the unused address 3, where a loose decode would emit stray data or corrupt a live register.

// File: rtl/iq_stim_pkg.sv
package iq_stim_pkg;
  localparam int SAMP_W = 16;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_ZERO    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_TONE    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_IMPULSE = 3'd2;
  localparam logic [MODE_W-1:0] MODE_PRBS    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_LOOP    = 3'd4;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_INC  = 2'd2;

  localparam logic signed [SAMP_W-1:0] IMP_LEVEL  = 16'sd32767;
  localparam logic signed [SAMP_W-1:0] PRBS_LEVEL = 16'sd16383;

  typedef struct packed {
    logic signed [SAMP_W-1:0] i;
    logic signed [SAMP_W-1:0] q;
  } iq_t;
endpackage

// File: rtl/stim_cfg_regs.sv
module stim_cfg_regs
  import iq_stim_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic                clk,
  input  logic                rst_ns,
  input  logic                we,
  input  logic [1:0]          addr,
  input  logic [PHASE_W-1:0]  wdata,
  output logic [MODE_W-1:0]   mode_q,
  output logic                en_q,
  output logic [PHASE_W-1:0]  inc_q,
  output logic                rearm,
  output logic                en_arm
);
  logic              mode_we, en_we, inc_we;
  logic [MODE_W-1:0] mode_d;
  logic              en_d;
  logic [PHASE_W-1:0] inc_d;

  always_comb begin
    mode_we = we && (addr == ADDR_MODE);
    en_we   = we && (addr == ADDR_EN);
    inc_we  = we && (addr == ADDR_INC);
    mode_d  = mode_we ? wdata[MODE_W-1:0] : mode_q;
    en_d    = en_we ? wdata[0] : en_q;
    inc_d   = inc_we ? wdata : inc_q;
    rearm   = mode_we;
    en_arm  = en_we && wdata[0] && !en_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q <= MODE_ZERO;
      en_q   <= 1'b0;
      inc_q  <= '0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      inc_q  <= inc_d;
    end
  end
endmodule

// File: rtl/stim_tone_nco.sv
module stim_tone_nco
  import iq_stim_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_ns,
  input  logic               clr,
  input  logic               adv,
  input  logic [PHASE_W-1:0] inc,
  output iq_t                tone
);
  localparam int LUT_IDX_W = 6;

  logic [PHASE_W-1:0]   phase_q, phase_d;
  logic [LUT_IDX_W-1:0] p6;

  function automatic logic signed [SAMP_W-1:0] quarter(input logic [4:0] k);
    case (k)
      5'd0:  return 16'sd0;
      5'd1:  return 16'sd3212;
      5'd2:  return 16'sd6393;
      5'd3:  return 16'sd9512;
      5'd4:  return 16'sd12539;
      5'd5:  return 16'sd15446;
      5'd6:  return 16'sd18204;
      5'd7:  return 16'sd20787;
      5'd8:  return 16'sd23170;
      5'd9:  return 16'sd25329;
      5'd10: return 16'sd27245;
      5'd11: return 16'sd28898;
      5'd12: return 16'sd30273;
      5'd13: return 16'sd31356;
      5'd14: return 16'sd32137;
      5'd15: return 16'sd32609;
      default: return 16'sd32767;
    endcase
  endfunction

  function automatic logic signed [SAMP_W-1:0] sine6(input logic [LUT_IDX_W-1:0] p);
    logic [4:0] k;
    k = p[4] ? (5'd16 - {1'b0, p[3:0]}) : {1'b0, p[3:0]};
    return p[5] ? -quarter(k) : quarter(k);
  endfunction

  always_comb begin
    if (clr)      phase_d = '0;
    else if (adv) phase_d = phase_q + inc;
    else          phase_d = phase_q;
    p6     = phase_q[PHASE_W-1 -: LUT_IDX_W];
    tone.q = sine6(p6);
    tone.i = sine6(p6 + 6'd16);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) phase_q <= '0;
    else         phase_q <= phase_d;
  end
endmodule

// File: rtl/stim_prbs.sv
module stim_prbs #(
  parameter int LFSR_W = 7
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic clr,
  input  logic adv,
  output logic bit_o
);
  logic [LFSR_W-1:0] s_q, s_d;

  always_comb begin
    if (clr)      s_d = '1;
    else if (adv) s_d = {s_q[LFSR_W-2:0], s_q[LFSR_W-1] ^ s_q[LFSR_W-2]};
    else          s_d = s_q;
    bit_o = s_q[LFSR_W-1];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) s_q <= '1;
    else         s_q <= s_d;
  end
endmodule

// File: rtl/iq_stim_gen.sv
module iq_stim_gen
  import iq_stim_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_addr,
  input  logic [PHASE_W-1:0]       cfg_wdata,
  input  logic                     lb_valid,
  output logic                     lb_ready,
  input  logic signed [SAMP_W-1:0] lb_i,
  input  logic signed [SAMP_W-1:0] lb_q,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q
);
  logic [1:0]         rst_pipe;
  logic               rst_ns;
  logic [MODE_W-1:0]  mode_q;
  logic               en_q;
  logic [PHASE_W-1:0] inc_q;
  logic               rearm, en_arm;
  logic               fire, is_loop;
  logic               pend_q, pend_d;
  logic               prbs_bit;
  iq_t                tone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  stim_cfg_regs #(.PHASE_W(PHASE_W)) u_cfg (
    .clk(clk), .rst_ns(rst_ns), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode_q(mode_q), .en_q(en_q), .inc_q(inc_q), .rearm(rearm), .en_arm(en_arm)
  );

  stim_tone_nco #(.PHASE_W(PHASE_W)) u_nco (
    .clk(clk), .rst_ns(rst_ns), .clr(rearm),
    .adv(fire && (mode_q == MODE_TONE)), .inc(inc_q), .tone(tone)
  );

  stim_prbs #(.LFSR_W(7)) u_prbs (
    .clk(clk), .rst_ns(rst_ns), .clr(rearm),
    .adv(fire && (mode_q == MODE_PRBS)), .bit_o(prbs_bit)
  );

  always_comb begin
    is_loop   = (mode_q == MODE_LOOP);
    out_valid = en_q && (is_loop ? lb_valid : 1'b1);
    lb_ready  = en_q && is_loop && out_ready;
    fire      = out_valid && out_ready;
    if (rearm || en_arm)                         pend_d = 1'b1;
    else if (fire && (mode_q == MODE_IMPULSE))   pend_d = 1'b0;
    else                                         pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) pend_q <= 1'b1;
    else         pend_q <= pend_d;
  end

  always_comb begin
    out_i = '0;
    out_q = '0;
    case (mode_q)
      MODE_TONE: begin
        out_i = tone.i;
        out_q = tone.q;
      end
      MODE_IMPULSE: out_i = pend_q ? IMP_LEVEL : '0;
      MODE_PRBS:    out_i = prbs_bit ? -PRBS_LEVEL : PRBS_LEVEL;
      MODE_LOOP: begin
        out_i = lb_i;
        out_q = lb_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iq_stim_gen_sva.sv
module iq_stim_gen_sva
  import iq_stim_pkg::*;
(
  input logic                     clk,
  input logic                     rst_ns,
  input logic [MODE_W-1:0]        mode,
  input logic                     enable,
  input logic                     cfg_we,
  input logic                     lb_valid,
  input logic                     lb_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [SAMP_W-1:0] out_i,
  input logic signed [SAMP_W-1:0] out_q
);
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    !enable |-> !out_valid);

  p_silence_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode == MODE_ZERO || mode > MODE_LOOP) |-> (out_i == 0 && out_q == 0));

  p_bit_levels_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode == MODE_PRBS) |-> (out_q == 0 && (out_i == 16'sd16383 || out_i == -16'sd16383)));

  p_passthrough_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode == MODE_LOOP && enable) |-> (out_valid == lb_valid && lb_ready == out_ready));

  p_no_lb_ready_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode != MODE_LOOP || !enable) |-> !lb_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !out_ready && !cfg_we && mode != MODE_LOOP)
      |=> (out_valid && $stable(out_i) && $stable(out_q)));
endmodule

bind iq_stim_gen iq_stim_gen_sva u_sva (
  .clk(clk), .rst_ns(rst_ns), .mode(mode_q), .enable(en_q), .cfg_we(cfg_we),
  .lb_valid(lb_valid), .lb_ready(lb_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
);

// File: tb/iq_stim_gen_tb.sv
module iq_stim_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic lb_valid = 1'b0;
  logic lb_ready;
  logic signed [15:0] lb_i = '0, lb_q = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic signed [15:0] out_i, out_q;

  int vectors = 0, fails = 0;

  // bench model of the register and generator state
  int m_mode = 0;
  bit m_en = 0;
  int m_inc = 0;
  int m_phase = 0;
  bit [6:0] m_lfsr = 7'h7f;
  bit m_pend = 1;
  bit prev_fire = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_stim_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .lb_valid(lb_valid), .lb_ready(lb_ready), .lb_i(lb_i), .lb_q(lb_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tone_ref(input int ph, input bit is_sin);
    int p6;
    real a;
    p6 = (ph >> 10) & 63;
    a = 2.0 * PI * p6 / 64.0;
    return is_sin ? int'(32767.0 * $sin(a)) : int'(32767.0 * $cos(a));
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // waits for the next falling edge and applies the transfer seen at the rising edge
  task automatic step_edge();
    @(negedge clk);
    if (prev_fire) begin
      if (m_mode == 1) m_phase = (m_phase + m_inc) & 16'hffff;
      if (m_mode == 3) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
      if (m_mode == 2) m_pend = 0;
    end
    prev_fire = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step_edge();
    out_ready = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step_edge();
    cfg_we = 1'b0;
    case (a)
      2'd0: begin m_mode = d[2:0]; m_phase = 0; m_lfsr = 7'h7f; m_pend = 1; end
      2'd1: begin if (d[0] && !m_en) m_pend = 1; m_en = d[0]; end
      2'd2: m_inc = d;
      default: ;
    endcase
  endtask

  task automatic run(input int n, input string tag, input int ready_pct);
    for (int k = 0; k < n; k++) begin
      bit lbv, exp_v;
      int ei, eq;
      if (k != 0) step_edge();
      lbv = ($urandom % 100) < 60;
      lb_valid = lbv;
      lb_i = 16'($urandom);
      lb_q = 16'($urandom);
      out_ready = ($urandom % 100) < ready_pct;
      #1;
      exp_v = m_en && ((m_mode == 4) ? lbv : 1'b1);
      check(out_valid == exp_v, {tag, " valid"}, out_valid, exp_v);
      check(lb_ready == (m_en && m_mode == 4 && out_ready), "R9 lb_ready", lb_ready,
            m_en && m_mode == 4 && out_ready);
      if (exp_v) begin
        case (m_mode)
          1: begin
            ei = tone_ref(m_phase, 0); eq = tone_ref(m_phase, 1);
            check(absd(int'(out_i), ei) <= 2, {tag, " tone I"}, out_i, ei);
            check(absd(int'(out_q), eq) <= 2, {tag, " tone Q"}, out_q, eq);
          end
          2: begin
            ei = m_pend ? 32767 : 0;
            check(int'(out_i) == ei && out_q == 0, {tag, " impulse"}, out_i, ei);
          end
          3: begin
            ei = m_lfsr[6] ? -16383 : 16383;
            check(int'(out_i) == ei && out_q == 0, {tag, " bit level"}, out_i, ei);
          end
          4: begin
            check(out_i == lb_i, {tag, " lb I"}, out_i, lb_i);
            check(out_q == lb_q, {tag, " lb Q"}, out_q, lb_q);
          end
          default: check(out_i == 0 && out_q == 0, {tag, " silence"}, out_i, 0);
        endcase
      end
      prev_fire = out_valid && out_ready;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic signed [15:0] hold_i, hold_q;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state, nothing enabled
    out_ready = 1'b1;
    #1;
    check(out_valid == 0, "R1 valid after reset", out_valid, 0);
    check(lb_ready == 0, "R1 lb_ready after reset", lb_ready, 0);
    run(10, "R3 disabled", 100);

    wr(2'd1, 16'h0001);
    run(50, "R4 mode0", 70);

    // R5 tone with a fixed step, then a random step after a mode rewrite (R11)
    wr(2'd2, 16'h0400);
    wr(2'd0, 16'd1);
    run(200, "R5 tone", 75);
    wr(2'd2, 16'($urandom));
    wr(2'd0, 16'd1);
    run(300, "R11 tone restart", 60);
    // R2: write to the spare address must not disturb the running tone
    wr(2'd3, 16'hffff);
    run(60, "R2 spare address", 80);

    // R10: hold under backpressure
    run(1, "R10 pre", 0);
    hold_i = out_i; hold_q = out_q;
    run(12, "R10 hold", 0);
    check(out_i == hold_i && out_q == hold_q, "R10 stable", out_i, hold_i);

    // R6 impulse, then re-arm by enable toggle
    wr(2'd0, 16'd2);
    run(40, "R6 impulse", 50);
    wr(2'd1, 16'h0000);
    run(8, "R3 off", 100);
    wr(2'd1, 16'h0001);
    run(20, "R6 re-enable", 50);

    // R7 and R8: bit stream and its restart
    wr(2'd0, 16'd3);
    run(300, "R7 prbs", 65);
    wr(2'd0, 16'd3);
    run(60, "R8 prbs restart", 90);

    // R9 passthrough
    wr(2'd0, 16'd4);
    run(200, "R9 loop", 50);

    // R4 undefined codes
    for (int c = 5; c < 8; c++) begin
      wr(2'd0, 16'(c));
      run(20, "R4 undefined", 70);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule